// File: doc/BRIEF.md
# Chained Command Descriptor Sequencer

The block is a single-channel engine that walks a linked list of command descriptors held in memory. Each descriptor names a pointer to the next descriptor, a control halfword, a byte count, a buffer address and up to fifteen register words. The engine reads the descriptor and writes its register words to a peripheral register port. It then moves data between the buffer and the peripheral in either direction, or moves nothing, and follows the chain pointer.

Software arms the channel by writing the first descriptor address while the channel is idle. It then adds to a semaphore count. The channel only leaves idle while the count is non-zero, and a descriptor may decrement the count when it completes. A chain can therefore pause partway and pick up again when more count is added. A freeze input holds all progress at a beat boundary. Malformed descriptors stop the channel with a sticky error flag.

Top module: `cdma_seq`

## Requirements
- R1: A descriptor at byte address A is read as word A+0 = next-descriptor address, word A+4 = control halfword in bits 15:0 and byte count in bits 31:16, word A+8 = buffer address, and words A+12 onward = register words.
- R2: Control bits 15:12 give a register-word count N (0..15). Word A+12+4i is written to peripheral register index i for i = 0..N-1, in ascending order and before any data beat.
- R3: Control bits 1:0 select the action. 0 moves no data. 1 pulls ceil(count/4) words from the peripheral and writes them to ascending buffer words. 2 reads ceil(count/4) ascending buffer words and pushes each to the peripheral.
- R4: With control bit 2 set, the next descriptor is fetched from the next-descriptor address after completion. With it clear, the channel returns to idle and stays disarmed.
- R5: Control bit 3 gives a one-cycle completion pulse on irq. Control bit 6 decrements the semaphore by one at completion.
- R6: A start-address write in idle arms the channel and clears the error flag. Semaphore writes add to the count, saturating at its maximum. An armed channel starts only while the count is non-zero. A chained descriptor that leaves the count at zero parks the channel until more count is added.
- R7: With control bit 7 set, completion waits until dev_end is seen after the register words and data beats.
- R8: A dev_term during data beats with control bit 8 set ends the descriptor without a completion pulse and disarms the channel. With only control bit 9 set, it ends the data beats early and completes normally.
- R9: Action code 3 or a byte count above 0xFF00 sets err and returns the channel to idle, disarmed, with no register write and no data beat. A count of exactly 0xFF00 runs.
- R10: Control bits 4, 5, 10 and 11 have no effect.
- R11: While freeze is high, no memory request, register write, data beat or completion pulse occurs. Processing resumes afterwards with no beat lost or repeated.
- R12: After reset the channel is idle and disarmed, with err and irq low, no memory request and a semaphore count of zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_addr_we | input | 1 | Start-address write strobe |
| cmd_addr | input | AW | First descriptor address |
| sema_we | input | 1 | Semaphore add strobe |
| sema_add | input | SEM_W | Amount added to the semaphore |
| freeze | input | 1 | Stall processing while high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| pio_we | output | 1 | Peripheral register write |
| pio_idx | output | 4 | Peripheral register index |
| pio_data | output | 32 | Peripheral register data |
| dev_push | output | 1 | Data word delivered to peripheral |
| dev_wdata | output | 32 | Word delivered to peripheral |
| dev_pull | output | 1 | Data word taken from peripheral |
| dev_rdata | input | 32 | Word offered by peripheral |
| dev_ready | input | 1 | Peripheral can move a data word |
| dev_end | input | 1 | Peripheral end-of-transfer |
| dev_term | input | 1 | Peripheral terminate request |
| irq | output | 1 | Completion pulse |
| err | output | 1 | Sticky descriptor error |
| idle | output | 1 | Channel is idle |
| sema_cnt | output | SEM_W | Current semaphore count |

## Verification
Register writes, data pushes, pulls and memory writes appear in the same cycle as the memory grant that carries them. The bench therefore compares each one, at the falling edge of that cycle, against the head of an expected queue. It builds those queues from the descriptor words before the run starts. A completion pulse comes one cycle after the last beat, or one cycle after dev_end. The semaphore and error flag change one edge after their cause. Outcomes are judged only once idle has held for three consecutive cycles, which cannot happen between two chained descriptors. Stalls come from a pseudo-random grant pattern, so expected events are tied to grants and not to absolute cycle numbers.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_TO_MEM = 2'd1,
    OP_TO_DEV = 2'd2,
    OP_SENSE  = 2'd3
  } op_e;

  // control halfword; bit positions are decoded by software-built descriptors
  typedef struct packed {
    logic [3:0] pio_n;   // 15:12
    logic [1:0] rsv_hi;  // 11:10
    logic       flush;   // 9
    logic       halt;    // 8
    logic       wend;    // 7
    logic       dsem;    // 6
    logic [1:0] rsv_lo;  // 5:4
    logic       irq;     // 3
    logic       chain;   // 2
    op_e        op;      // 1:0
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_NXT, S_CTL, S_BUF, S_PIO, S_XFER, S_WEND, S_DONE
  } st_e;

  localparam int BEAT_W = 15;

  // number of 32-bit beats covering a byte count
  function automatic logic [BEAT_W-1:0] beats_of(input logic [15:0] nbytes);
    logic [16:0] t;
    t = {1'b0, nbytes} + 17'd3;
    return t[16:2];
  endfunction

endpackage

// File: rtl/cdma_sema.sv
module cdma_sema #(
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [SEM_W-1:0] add_val,
  input  logic             dec,
  output logic [SEM_W-1:0] count
);
  localparam logic [SEM_W:0] SAT = {1'b0, {SEM_W{1'b1}}};

  function automatic logic [SEM_W-1:0] sema_upd(input logic [SEM_W-1:0] cur,
                                                input logic en, input logic [SEM_W-1:0] v,
                                                input logic d);
    logic [SEM_W:0] s;
    s = {1'b0, cur} + (en ? {1'b0, v} : '0);
    if (s > SAT) s = SAT;
    if (d && s != '0) s = s - 1'b1;
    return s[SEM_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= sema_upd(count, add_en, add_val, dec);
  end

  assert_sema_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !dec) |=> $stable(count));
  assert_sema_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !add_en && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/cdma_decode.sv
module cdma_decode
  import cdma_pkg::*;
#(
  parameter logic [15:0] MAX_BYTES = 16'hFF00
) (
  input  logic [31:0]       word,
  output ctl_t              ctl,
  output logic [BEAT_W-1:0] beats,
  output logic              bad
);
  logic [15:0] nbytes;
  assign ctl    = ctl_t'(word[15:0]);
  assign nbytes = word[31:16];
  assign beats  = beats_of(nbytes);
  assign bad    = (ctl.op == OP_SENSE) || (nbytes > MAX_BYTES);
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          SEM_W     = 8,
  parameter logic [15:0] MAX_BYTES = 16'hFF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_addr_we,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             sema_we,
  input  logic [SEM_W-1:0] sema_add,
  input  logic             freeze,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             pio_we,
  output logic [3:0]       pio_idx,
  output logic [31:0]      pio_data,
  output logic             dev_push,
  output logic [31:0]      dev_wdata,
  output logic             dev_pull,
  input  logic [31:0]      dev_rdata,
  input  logic             dev_ready,
  input  logic             dev_end,
  input  logic             dev_term,
  output logic             irq,
  output logic             err,
  output logic             idle,
  output logic [SEM_W-1:0] sema_cnt
);
  localparam logic [BEAT_W-1:0] MAX_BEATS = beats_of(MAX_BYTES);

  st_e               state_q;
  logic [AW-1:0]     ptr_q, nxt_q, buf_q;
  ctl_t              ctl_q;
  logic [BEAT_W-1:0] beats_q;
  logic [3:0]        idx_q;
  logic              armed_q, err_q;

  ctl_t              d_ctl;
  logic [BEAT_W-1:0] d_beats;
  logic              d_bad;

  // named internal events
  logic go, fire, start_ok, term_hit, done_ev, sem_dec, ctl_fire;
  st_e  after_pio, after_xfer;

  cdma_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .word(mem_rdata), .ctl(d_ctl), .beats(d_beats), .bad(d_bad)
  );

  cdma_sema #(.SEM_W(SEM_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .add_en(sema_we), .add_val(sema_add),
    .dec(sem_dec), .count(sema_cnt)
  );

  assign go         = !freeze;
  assign start_ok   = go && armed_q && (sema_cnt != '0) && !cmd_addr_we;
  assign after_xfer = ctl_q.wend ? S_WEND : S_DONE;
  assign after_pio  = (ctl_q.op != OP_NONE && beats_q != '0) ? S_XFER : after_xfer;

  always_comb begin
    mem_addr = buf_q;
    unique case (state_q)
      S_NXT:   mem_addr = ptr_q;
      S_CTL:   mem_addr = ptr_q + AW'(4);
      S_BUF:   mem_addr = ptr_q + AW'(8);
      S_PIO:   mem_addr = ptr_q + AW'(12) + AW'({idx_q, 2'b00});
      default: mem_addr = buf_q;
    endcase
  end

  always_comb begin
    mem_req = 1'b0;
    if (go) begin
      unique case (state_q)
        S_NXT, S_CTL, S_BUF, S_PIO: mem_req = 1'b1;
        S_XFER:                     mem_req = dev_ready;
        default:                    mem_req = 1'b0;
      endcase
    end
  end

  assign fire      = mem_req && mem_gnt;
  assign ctl_fire  = fire && (state_q == S_CTL);
  assign mem_we    = (state_q == S_XFER) && (ctl_q.op == OP_TO_MEM);
  assign mem_wdata = dev_rdata;
  assign pio_we    = fire && (state_q == S_PIO);
  assign pio_idx   = idx_q;
  assign pio_data  = mem_rdata;
  assign dev_push  = fire && (state_q == S_XFER) && (ctl_q.op == OP_TO_DEV);
  assign dev_pull  = fire && (state_q == S_XFER) && (ctl_q.op == OP_TO_MEM);
  assign dev_wdata = mem_rdata;
  assign term_hit  = go && (state_q == S_XFER) && dev_term && (ctl_q.halt || ctl_q.flush);
  assign done_ev   = go && (state_q == S_DONE);
  assign sem_dec   = done_ev && ctl_q.dsem;
  assign irq       = done_ev && ctl_q.irq;
  assign err       = err_q;
  assign idle      = (state_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      ctl_q   <= '0;
      beats_q <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_addr_we) begin
            ptr_q   <= cmd_addr;
            armed_q <= 1'b1;
            err_q   <= 1'b0;
          end else if (start_ok) state_q <= S_NXT;
        end
        S_NXT: if (fire) begin
          nxt_q   <= mem_rdata[AW-1:0];
          state_q <= S_CTL;
        end
        S_CTL: if (fire) begin
          ctl_q   <= d_ctl;
          beats_q <= d_beats;
          if (d_bad) begin
            err_q   <= 1'b1;
            armed_q <= 1'b0;
            state_q <= S_IDLE;
          end else state_q <= S_BUF;
        end
        S_BUF: if (fire) begin
          buf_q   <= mem_rdata[AW-1:0];
          idx_q   <= '0;
          state_q <= (ctl_q.pio_n != '0) ? S_PIO : after_pio;
        end
        S_PIO: if (fire) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == ctl_q.pio_n - 1'b1) state_q <= after_pio;
        end
        S_XFER: begin
          if (term_hit) begin
            if (ctl_q.halt) begin
              armed_q <= 1'b0;
              state_q <= S_IDLE;
            end else state_q <= after_xfer;
          end else if (fire) begin
            buf_q   <= buf_q + AW'(4);
            beats_q <= beats_q - 1'b1;
            if (beats_q == BEAT_W'(1)) state_q <= after_xfer;
          end
        end
        S_WEND: if (go && dev_end) state_q <= S_DONE;
        S_DONE: if (go) begin
          if (ctl_q.chain) ptr_q <= nxt_q;
          armed_q <= ctl_q.chain;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: a frozen busy channel keeps all of its progress state
  assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && state_q != S_IDLE) |=> ($stable(state_q) && $stable(beats_q) && $stable(buf_q)));
  // R9: a malformed control word ends in idle with the error flag
  assert_bad_desc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && d_bad) |=> (err_q && state_q == S_IDLE));
  // R5: completion pulse lasts one cycle
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R2: register writes stay below the word count
  assert_pio_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pio_we |-> (pio_idx < ctl_q.pio_n));
  // R9: no data phase ever runs longer than the byte limit allows
  assert_xfer_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XFER) |-> (beats_q <= MAX_BEATS));
  // R8: a halting terminate gives no completion
  assert_term_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && ctl_q.halt) |=> (state_q == S_IDLE && !irq));

endmodule

// File: tb/cdma_seq_bench.sv
module cdma_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_addr_we = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic        sema_we = 1'b0;
  logic [7:0]  sema_add = '0;
  logic        freeze = 1'b0;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pio_we, dev_push, dev_pull, irq, err, idle;
  logic [3:0]  pio_idx;
  logic [31:0] pio_data, dev_wdata, dev_rdata;
  logic        dev_ready, dev_end = 1'b0, dev_term = 1'b0;
  logic [7:0]  sema_cnt;

  logic [31:0] mem [0:255];
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_en = 1'b1;
  int          pull_cnt = 0, exp_pulls = 0, irq_cnt = 0, exp_irq = 0;
  int          n_chk = 0, n_fail = 0;
  bit          running = 1'b0;

  logic [35:0] exp_pio  [$];
  logic [31:0] exp_push [$];
  logic [63:0] exp_mw   [$];

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign mem_gnt   = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  assign dev_ready = stall_en ? (lfsr[1] | lfsr[5]) : 1'b1;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign dev_rdata = 32'hD000_0000 + 32'(pull_cnt);

  cdma_seq u_cdma_seq (
    .clk(clk), .rst_n(rst_n), .cmd_addr_we(cmd_addr_we), .cmd_addr(cmd_addr),
    .sema_we(sema_we), .sema_add(sema_add), .freeze(freeze),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .pio_we(pio_we), .pio_idx(pio_idx),
    .pio_data(pio_data), .dev_push(dev_push), .dev_wdata(dev_wdata), .dev_pull(dev_pull),
    .dev_rdata(dev_rdata), .dev_ready(dev_ready), .dev_end(dev_end), .dev_term(dev_term),
    .irq(irq), .err(err), .idle(idle), .sema_cnt(sema_cnt)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // event monitor: compares every observable beat against the expected queues
  always @(negedge clk) if (rst_n && running) begin
    if (pio_we) begin
      if (exp_pio.size() == 0) check(0, "R2 unexpected register write", {pio_idx, pio_data}, 0);
      else begin
        logic [35:0] e;
        e = exp_pio.pop_front();
        check({pio_idx, pio_data} == e, "R2 register write", {pio_idx, pio_data}, e);
      end
    end
    if (dev_push) begin
      if (exp_push.size() == 0) check(0, "R3 unexpected push", dev_wdata, 0);
      else begin
        logic [31:0] e;
        e = exp_push.pop_front();
        check(dev_wdata == e, "R3 push data", dev_wdata, e);
      end
    end
    if (mem_req && mem_we && mem_gnt) begin
      if (exp_mw.size() == 0) check(0, "R3 unexpected memory write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [63:0] e;
        e = exp_mw.pop_front();
        check({mem_addr, mem_wdata} == e, "R3 memory write", {mem_addr, mem_wdata}, e);
      end
      mem[mem_addr[9:2]] = mem_wdata;
    end
    if (dev_pull) pull_cnt++;
    if (irq) irq_cnt++;
    if (freeze) check(!mem_req && !pio_we && !irq, "R11 activity while frozen",
                      {mem_req, pio_we, irq}, 0);
  end

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [15:0] ctl,
                          input logic [15:0] nbytes, input logic [31:0] bufa);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = {nbytes, ctl};
    mem[a/4 + 2] = bufa;
    for (int i = 0; i < int'(ctl[15:12]); i++) mem[a/4 + 3 + i] = 32'hA000_0000 | (a << 8) | i;
  endtask

  // behavioural model: expected events of one normally completing descriptor
  task automatic expect_desc(input int a);
    logic [15:0] ctl, nb;
    logic [31:0] bufa;
    int beats;
    ctl  = mem[a/4 + 1][15:0];
    nb   = mem[a/4 + 1][31:16];
    bufa = mem[a/4 + 2];
    for (int i = 0; i < int'(ctl[15:12]); i++) exp_pio.push_back({4'(i), mem[a/4 + 3 + i]});
    beats = (int'(nb) + 3) / 4;
    if (ctl[1:0] == 2'd2)
      for (int k = 0; k < beats; k++) exp_push.push_back(mem[((bufa >> 2) + k) % 256]);
    if (ctl[1:0] == 2'd1)
      for (int k = 0; k < beats; k++) begin
        exp_mw.push_back({bufa + 32'(4*k), 32'hD000_0000 + 32'(exp_pulls)});
        exp_pulls++;
      end
    if (ctl[3]) exp_irq++;
  endtask

  task automatic wr_addr(input logic [31:0] a);
    @(posedge clk); #1 cmd_addr_we = 1'b1; cmd_addr = a;
    @(posedge clk); #1 cmd_addr_we = 1'b0;
  endtask

  task automatic add_sema(input logic [7:0] v);
    @(posedge clk); #1 sema_we = 1'b1; sema_add = v;
    @(posedge clk); #1 sema_we = 1'b0;
  endtask

  task automatic wait_idle();
    int st = 0;
    while (st < 3) begin
      @(negedge clk);
      st = idle ? st + 1 : 0;
    end
  endtask

  task automatic queues_empty(input string tag);
    check(exp_pio.size() == 0,  {tag, " register writes all seen"}, exp_pio.size(), 0);
    check(exp_push.size() == 0, {tag, " pushes all seen"}, exp_push.size(), 0);
    check(exp_mw.size() == 0,   {tag, " memory writes all seen"}, exp_mw.size(), 0);
    check(irq_cnt == exp_irq,   {tag, " completion pulses"}, irq_cnt, exp_irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hB000_0000 + i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(idle && !err && !irq && !mem_req && sema_cnt == 0, "R12 reset state",
          {idle, err, irq, mem_req, sema_cnt}, {4'b1000, 8'd0});
    running = 1'b1;

    // R1 R2 R3 R4: read-direction descriptor chained to a write-direction one
    put_desc(32'h000, 32'h040, 16'h2006, 16'd8, 32'h300);
    put_desc(32'h040, 32'h000, 16'h0049, 16'd6, 32'h340);
    expect_desc(32'h000);
    expect_desc(32'h040);
    wr_addr(32'h000);
    add_sema(8'd1);
    wait_idle();
    queues_empty("R1 R3 R4 chain");
    check(sema_cnt == 0, "R5 semaphore decremented", sema_cnt, 0);

    // R6: chain parks at zero count, resumes after an add
    put_desc(32'h080, 32'h0C0, 16'h104C, 16'd0, 32'h0);
    put_desc(32'h0C0, 32'h000, 16'h1048, 16'd0, 32'h0);
    expect_desc(32'h080);
    wr_addr(32'h080);
    add_sema(8'd1);
    wait_idle();
    repeat (20) @(negedge clk);
    check(idle, "R6 parked while count zero", idle, 1);
    queues_empty("R6 parked");
    expect_desc(32'h0C0);
    add_sema(8'd1);
    wait_idle();
    queues_empty("R6 resumed");
    add_sema(8'd200);
    add_sema(8'd100);
    @(negedge clk);
    check(sema_cnt == 8'd255, "R6 saturating add", sema_cnt, 255);
    check(idle, "R4 unchained end stays disarmed", idle, 1);

    // R7: wait for end of transfer
    put_desc(32'h100, 32'h000, 16'h0088, 16'd0, 32'h0);
    wr_addr(32'h100);
    repeat (20) @(negedge clk);
    check(!idle && irq_cnt == exp_irq, "R7 waits for end", {idle, 32'(irq_cnt)}, {1'b0, 32'(exp_irq)});
    exp_irq++;
    @(posedge clk); #1 dev_end = 1'b1;
    @(posedge clk); #1 dev_end = 1'b0;
    wait_idle();
    queues_empty("R7 after end");

    // R9: unsupported action and oversize count
    put_desc(32'h140, 32'h000, 16'h200B, 16'd4, 32'h300);
    wr_addr(32'h140);
    wait_idle();
    check(err, "R9 action code 3 sets err", err, 1);
    queues_empty("R9 action code 3");
    put_desc(32'h180, 32'h000, 16'h000A, 16'hFF01, 32'h300);
    wr_addr(32'h180);
    @(negedge clk);
    check(!err, "R6 start-address write clears err", err, 0);
    wait_idle();
    check(err, "R9 count above limit sets err", err, 1);
    queues_empty("R9 oversize");
    stall_en = 1'b0;
    put_desc(32'h1C0, 32'h000, 16'h0002, 16'hFF00, 32'h0);
    expect_desc(32'h1C0);
    wr_addr(32'h1C0);
    wait_idle();
    check(!err, "R9 count at limit runs", err, 0);
    queues_empty("R9 limit");
    stall_en = 1'b1;

    // R10: reserved control bits ignored
    put_desc(32'h200, 32'h000, 16'h1C38, 16'd0, 32'h0);
    expect_desc(32'h200);
    wr_addr(32'h200);
    wait_idle();
    check(!err, "R10 reserved bits no error", err, 0);
    queues_empty("R10 reserved bits");

    // R11: freeze in the middle of a descriptor
    put_desc(32'h240, 32'h000, 16'h200A, 16'd32, 32'h300);
    expect_desc(32'h240);
    wr_addr(32'h240);
    repeat (4) @(posedge clk);
    #1 freeze = 1'b1;
    repeat (12) @(posedge clk);
    #1 freeze = 1'b0;
    wait_idle();
    queues_empty("R11 freeze");

    // R8: terminate with halt, then with flush only
    stall_en = 1'b0;
    put_desc(32'h280, 32'h000, 16'h010A, 16'd16, 32'h300);
    exp_push.push_back(mem[8'hC0]);
    dev_term = 1'b1;
    wr_addr(32'h280);
    wait_idle();
    queues_empty("R8 halt");
    add_sema(8'd0);
    repeat (10) @(negedge clk);
    check(idle, "R8 halt leaves channel disarmed", idle, 1);
    put_desc(32'h2C0, 32'h000, 16'h020A, 16'd16, 32'h300);
    exp_push.push_back(mem[8'hC0]);
    exp_irq++;
    wr_addr(32'h2C0);
    wait_idle();
    queues_empty("R8 flush");
    dev_term = 1'b0;

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule